// File: doc/BRIEF.md
# Compare-Driven Timer Channel

A single up-counting timer channel on a simple register bus. A free-running prescaler divides the one input clock by one of five powers of two and emits single-cycle count-enable ticks. The counter advances on each tick while the channel's clock is switched on. Each tick compares the count with a programmable compare value. On a match the count returns to zero. In periodic mode it carries on counting, which gives a steady event every `cmp+1` ticks. In one-shot mode the channel clock switches itself off after the match.

Software starts the channel by writing a command word that switches the clock on and restarts the count in one step. It stops the channel with a clock-off command. The match event sets a sticky status flag that clears when software reads it, and the interrupt line is high while that flag and its mask bit are both set. The mask has separate set and clear addresses, plus a readback address.

Top module: `tmr_channel`

## Requirements
- R1: After reset the count reads 0, mode reads 0, compare reads 0xFFFF, status reads 0, mask reads 0 and `irq_o` is low.
- R2: A write to the command address (0) acts on three bits. Bit 0 switches the channel clock on. Bit 1 switches it off and takes priority over bit 0. Bit 2 forces the count and the prescaler to zero without changing the on/off state. While the clock is off the count holds.
- R3: Mode bits [2:0] select the tick rate. A value k in 0..4 advances the count once every 2^(1+2k) input cycles, and the values 5..7 behave as 4. After a write that carries bit 2, the count reads floor(j/D) when it is read j cycles after the write edge.
- R4: In periodic mode (mode bit 3 = 0) the count steps 0,1,..,C and then returns to 0, where C is the compare value (address 2). Each return sets status bit 0.
- R5: In one-shot mode (mode bit 3 = 1) a match returns the count to 0, sets status bit 0 and switches the channel clock off.
- R6: Status (address 4) reports the sticky match flag in bit 0 and the live clock-on state in bit 2. A read clears bit 0. A match in the same cycle as that read leaves bit 0 set.
- R7: Writing a one to bit 0 at address 5 sets the mask bit. Writing a one to bit 0 at address 6 clears it, so writing 0xFF there masks the source. Address 7 reads the mask in bit 0.
- R8: `irq_o` is high exactly while the match flag and the mask bit are both set. It changes in the cycle after the edge that changes either of them.
- R9: `rdata_o` is registered and takes the addressed value on the edge where `rd_i` is sampled. Addresses 0, 5 and 6 read as 0.
- R10: Compare (address 2) and mode (address 1) read back the value last written, using all 16 compare bits and the mode bits [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Interrupt, match flag AND mask |

## Verification
A command write that restarts the count takes effect at its own edge. The first tick then falls D cycles later, so after j cycles the count equals floor(j/D), and in periodic mode it wraps modulo C+1. The driver keeps a running cycle offset from the last restart and pushes the value expected at each read. The monitor compares each popped value one cycle after the strobe, because a read result appears one cycle after its strobe. The same-cycle read-versus-match case puts the status read exactly on the match edge at 2(C+1). The interrupt is checked on the falling edge that follows the match, the read or the mask write that moves it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    A_CMD  = 3'd0,
    A_MODE = 3'd1,
    A_CMP  = 3'd2,
    A_CNT  = 3'd3,
    A_STAT = 3'd4,
    A_IEN  = 3'd5,
    A_IDIS = 3'd6,
    A_MASK = 3'd7
  } tmr_addr_e;

  localparam int CMD_ON_BIT   = 0;
  localparam int CMD_OFF_BIT  = 1;
  localparam int CMD_TRIG_BIT = 2;
  localparam int ST_MATCH_BIT = 0;
  localparam int ST_RUN_BIT   = 2;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int N_SEL  = 5,
  parameter int SHIFT0 = 1,
  parameter int STEP   = 2,
  parameter int SEL_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int PRE_W = SHIFT0 + STEP * (N_SEL - 1);

  logic [PRE_W-1:0] pre_q;
  logic [N_SEL-1:0] tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pre_q <= '0;
    else if (clr_i) pre_q <= '0;
    else            pre_q <= pre_q + 1'b1;
  end

  for (genvar k = 0; k < N_SEL; k++) begin : g_tap
    assign tap[k] = &pre_q[SHIFT0 + STEP * k - 1:0];
  end

  // out-of-range selects fall back to the slowest tap
  always_comb begin
    tick_o = tap[N_SEL-1];
    for (int k = 0; k < N_SEL; k++)
      if (sel_i == SEL_W'(k)) tick_o = tap[k];
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             on_i,
  input  logic             off_i,
  input  logic             trig_i,
  input  logic             oneshot_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             step;

  assign step    = run_q & tick_i & ~trig_i;
  assign match_o = step & (cnt_q == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (trig_i)       cnt_q <= '0;
      else if (match_o) cnt_q <= '0;
      else if (step)    cnt_q <= cnt_q + 1'b1;

      if (off_i)                     run_q <= 1'b0;
      else if (on_i)                 run_q <= 1'b1;
      else if (match_o && oneshot_i) run_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic match_i,
  input  logic stat_rd_i,
  input  logic en_set_i,
  input  logic en_clr_i,
  output logic flag_o,
  output logic mask_o,
  output logic irq_o
);
  logic flag_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      flag_q <= (flag_q & ~stat_rd_i) | match_i;  // a same-cycle event wins over the clear
      if (en_set_i)      mask_q <= 1'b1;
      else if (en_clr_i) mask_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign mask_o = mask_q;
  assign irq_o  = flag_q & mask_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int N_SEL      = 5,
  parameter int PRE_SHIFT0 = 1,
  parameter int PRE_STEP   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [2:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_o
);
  localparam int SEL_W    = $clog2(N_SEL);
  localparam int STOP_BIT = SEL_W;

  logic             wr_cmd, cmd_on, cmd_off, cmd_trig;
  logic [SEL_W-1:0] sel_q;
  logic             stop_q;
  logic [CNT_W-1:0] cmp_q, cnt, rd_val;
  logic             tick, run, match, flag, mask_bit, stat_rd;

  assign wr_cmd   = wr_i && (addr_i == A_CMD);
  assign cmd_on   = wr_cmd & wdata_i[CMD_ON_BIT];
  assign cmd_off  = wr_cmd & wdata_i[CMD_OFF_BIT];
  assign cmd_trig = wr_cmd & wdata_i[CMD_TRIG_BIT];
  assign stat_rd  = rd_i && (addr_i == A_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      stop_q <= 1'b0;
      cmp_q  <= '1;
    end else if (wr_i) begin
      if (addr_i == A_MODE) begin
        sel_q  <= wdata_i[SEL_W-1:0];
        stop_q <= wdata_i[STOP_BIT];
      end
      if (addr_i == A_CMP) cmp_q <= wdata_i;
    end
  end

  tmr_prescale #(
    .N_SEL (N_SEL),
    .SHIFT0(PRE_SHIFT0),
    .STEP  (PRE_STEP),
    .SEL_W (SEL_W)
  ) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cmd_trig),
    .sel_i (sel_q),
    .tick_o(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .on_i     (cmd_on),
    .off_i    (cmd_off),
    .trig_i   (cmd_trig),
    .oneshot_i(stop_q),
    .cmp_i    (cmp_q),
    .cnt_o    (cnt),
    .run_o    (run),
    .match_o  (match)
  );

  tmr_irq u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .match_i  (match),
    .stat_rd_i(stat_rd),
    .en_set_i (wr_i && (addr_i == A_IEN) && wdata_i[0]),
    .en_clr_i (wr_i && (addr_i == A_IDIS) && wdata_i[0]),
    .flag_o   (flag),
    .mask_o   (mask_bit),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_val = '0;
    case (tmr_addr_e'(addr_i))
      A_MODE: begin
        rd_val[SEL_W-1:0] = sel_q;
        rd_val[STOP_BIT]  = stop_q;
      end
      A_CMP:  rd_val = cmp_q;
      A_CNT:  rd_val = cnt;
      A_STAT: begin
        rd_val[ST_MATCH_BIT] = flag;
        rd_val[ST_RUN_BIT]   = run;
      end
      A_MASK: rd_val[0] = mask_bit;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_val;
  end
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_i,
  input logic             rd_i,
  input logic [2:0]       addr_i,
  input logic [CNT_W-1:0] wdata_i,
  input logic [CNT_W-1:0] rdata_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] cnt,
  input logic             run,
  input logic             match,
  input logic             flag,
  input logic             stop_q
);
  logic trig_wr;
  assign trig_wr = wr_i && (addr_i == 3'd0) && wdata_i[2];

  a_r2_off_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 3'd0 && wdata_i[1]) |=> !run);

  a_r2_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !trig_wr) |=> $stable(cnt));

  a_r3_step_or_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_wr && !match) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

  a_r4_match_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> (cnt == '0));

  a_r5_oneshot_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && stop_q && !(wr_i && addr_i == 3'd0 && wdata_i[0])) |=> !run);

  a_r6_match_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> flag);

  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 3'd4 && !match) |=> !flag);

  a_r8_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> flag);

  a_r9_cnt_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 3'd3) |=> (rdata_o == $past(cnt)));
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_i   (wr_i),
  .rd_i   (rd_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .cnt    (cnt),
  .run    (run),
  .match  (match),
  .flag   (flag),
  .stop_q (stop_q)
);

// File: tb/test_tmr_channel.sv
`timescale 1ns/1ps
module test_tmr_channel;
  localparam logic [2:0] CMD = 3'd0, MODE = 3'd1, CMP = 3'd2, CNT = 3'd3,
                         STAT = 3'd4, IEN = 3'd5, IDIS = 3'd6, MSK = 3'd7;

  logic        clk = 1'b0, rst_ni = 1'b0, wr = 1'b0, rd = 1'b0, done = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  string       tag_q[$];
  logic [15:0] exp_q[$];
  logic        rd_d = 1'b0;

  always #2.5 clk = ~clk;

  tmr_channel i_tmr_channel (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] a, logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); @(negedge clk);
    wr = 1'b0;
  endtask

  // driver: pushes the expected item, the monitor pops it when data is due
  task automatic rd_reg(logic [2:0] a, string tag, logic [15:0] exp);
    addr = a; rd = 1'b1;
    tag_q.push_back(tag); exp_q.push_back(exp);
    @(posedge clk); @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) rd_d <= rd;

  always @(negedge clk) begin
    string t;
    logic [15:0] e;
    if (rd_d) begin
      if (exp_q.size() == 0) check("R9 unexpected read", rdata, 16'hxxxx);
      else begin
        t = tag_q.pop_front();
        e = exp_q.pop_front();
        check(t, rdata, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    // R1 reset state, R9 write-only reads zero
    check("R1 irq", {15'b0, irq}, 16'h0);
    rd_reg(CNT,  "R1 count", 16'h0000);
    rd_reg(MODE, "R1 mode", 16'h0000);
    rd_reg(CMP,  "R1 compare", 16'hFFFF);
    rd_reg(STAT, "R1 status", 16'h0000);
    rd_reg(MSK,  "R1 mask", 16'h0000);
    rd_reg(CMD,  "R9 cmd reads 0", 16'h0000);
    // R3 divide by 2, R2 start+trigger
    wr_reg(CMD, 16'h5);
    idle(9);
    rd_reg(CNT, "R3 div2 count", 16'd4);
    wr_reg(CMD, 16'h2);                     // R2 clock off at j=11
    idle(10);
    rd_reg(CNT,  "R2 hold after off", 16'd5);
    rd_reg(STAT, "R2 not running", 16'h0000);
    wr_reg(CMD, 16'h4);                     // R2 trigger alone
    rd_reg(CNT,  "R2 trigger zeroes", 16'd0);
    rd_reg(STAT, "R2 trigger keeps off", 16'h0000);
    wr_reg(CMD, 16'h7);                     // R2 off has priority
    rd_reg(STAT, "R2 off wins over on", 16'h0000);
    // R3 other divisors
    wr_reg(MODE, 16'h1); wr_reg(CMD, 16'h5); idle(20);
    rd_reg(CNT, "R3 div8 count", 16'd2);
    wr_reg(MODE, 16'h3); wr_reg(CMD, 16'h5); idle(300);
    rd_reg(CNT, "R3 div128 count", 16'd2);
    wr_reg(MODE, 16'h4); wr_reg(CMD, 16'h5); idle(1100);
    rd_reg(CNT, "R3 div512 count", 16'd2);
    wr_reg(MODE, 16'h7); wr_reg(CMD, 16'h5); idle(1100);
    rd_reg(CNT, "R3 sel7 as sel4", 16'd2);
    wr_reg(CMD, 16'h2);
    // R4 periodic with compare 3
    wr_reg(MODE, 16'h0); wr_reg(CMP, 16'd3);
    rd_reg(STAT, "R4 drain", 16'h0000);
    wr_reg(CMD, 16'h5); idle(9);
    rd_reg(CNT,  "R4 wrapped to 0", 16'd0);
    rd_reg(CNT,  "R4 after wrap", 16'd1);
    rd_reg(STAT, "R4 match flag", 16'h0005);
    rd_reg(STAT, "R6 flag cleared", 16'h0004);
    wr_reg(IEN, 16'h1);
    wr_reg(CMD, 16'h2);
    rd_reg(STAT, "R6 drain", 16'h0000);
    // R6 read on the match edge
    wr_reg(CMD, 16'h5); idle(7);
    rd_reg(STAT, "R6 read on match edge", 16'h0004);
    check("R8 irq after same-cycle match", {15'b0, irq}, 16'h1);
    rd_reg(STAT, "R6 event kept", 16'h0005);
    check("R8 irq low after read", {15'b0, irq}, 16'h0);
    // R7 mask set/clear
    idle(8);
    check("R8 irq next period", {15'b0, irq}, 16'h1);
    wr_reg(IDIS, 16'hFF);
    check("R7 irq masked", {15'b0, irq}, 16'h0);
    rd_reg(MSK, "R7 mask cleared", 16'h0000);
    wr_reg(IEN, 16'h1);
    check("R8 irq unmasked", {15'b0, irq}, 16'h1);
    rd_reg(MSK,  "R7 mask set", 16'h0001);
    rd_reg(STAT, "R7 flag survived mask", 16'h0005);
    // R5 one-shot
    wr_reg(CMD, 16'h2);
    wr_reg(MODE, 16'h8);
    rd_reg(STAT, "R5 drain", 16'h0000);
    wr_reg(CMD, 16'h5); idle(20);
    rd_reg(CNT,  "R5 count back to 0", 16'd0);
    rd_reg(STAT, "R5 stopped with flag", 16'h0001);
    check("R8 irq cleared by read", {15'b0, irq}, 16'h0);
    // R10 readback
    wr_reg(CMP, 16'hA5C3);
    rd_reg(CMP,  "R10 compare readback", 16'hA5C3);
    rd_reg(MODE, "R10 mode readback", 16'h0008);
    rd_reg(IEN,  "R9 enable reads 0", 16'h0000);
    idle(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule